// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

The watchdog counts down slow ticks from a value software writes into a single 32-bit control word. The same word carries a run command and a 7-bit key. When the control word stored last has its run bit set, software has to present the bitwise inverse of the stored key to get a new word accepted. Any other write is dropped without trace. Each accepted word becomes the new stored word, so the required key alternates from one service to the next.

The countdown has two stages. When the main count expires, the block raises a non-maskable interrupt level and loads a short grace count. If software services the watchdog with a valid write before the grace count runs out, the interrupt is cleared and the main count restarts. If the grace count expires as well, the block emits a one-cycle system reset request and stops counting. The slow tick arrives as an enable strobe from elsewhere in the chip, nominally near 760 Hz.

Top module: `watchdog_keyed`

## Requirements
- R1: After reset, the stored control word is zero and the counter is stopped. `nmiOut` and `resetReqOut` are low, and no number of ticks produces an expiry.
- R2: Control word fields: bits [7:0] hold the count, bit 8 is the run command and bits [15:9] hold the key. While the stored bit 8 is 0, a write is accepted whatever its key.
- R3: While the stored bit 8 is 1, a write is accepted only if its key field equals the bitwise inverse of the stored key field. Any other write leaves the counter, the stage and both outputs unchanged.
- R4: An accepted write reloads the counter with the count field. A count field of 0 loads 256.
- R5: While running, the counter drops by one on each cycle with `tickEn` high. With a load of N, the first expiry happens on the Nth tick after the write.
- R6: An accepted write with bit 8 at 0 stops the counter, and no later tick produces an expiry.
- R7: The first expiry sets `nmiOut` in the cycle after the expiring tick and loads a grace count of GRACE_TICKS ticks. `nmiOut` stays high until an accepted write or a reset.
- R8: An expiry of the grace count pulses `resetReqOut` high for exactly one cycle, while `nmiOut` is still high, and stops the counter.
- R9: An accepted write clears `nmiOut` and the stage, so the next expiry raises the interrupt again rather than requesting a reset.
- R10: When an accepted write and a tick fall in the same cycle, the write wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow tick strobe, one cycle per tick |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word to write |
| nmiOut | output | 1 | Non-maskable interrupt level, set on first expiry |
| resetReqOut | output | 1 | One-cycle system reset request on grace expiry |

## Verification
The main countdown is swept over count fields 0, 1, 2, 3, 5, 8, 17 and 255. Each sweep step checks that the interrupt stays low one tick before the expected expiry and rises exactly on it, which separates off-by-one reloads and the zero-means-256 case from correct ones. Every step then follows the grace stage through to its single reset pulse.

Every one of the 127 wrong keys is written against a locked word. The expiry time afterwards shows that none of them reloaded the counter, and the one correct key is then shown to be accepted. Separate runs cover a stop command, unlocked writes with arbitrary keys, and a write that lands on the same cycle as a tick. Between them these tell write priority, stop handling and stage clearing apart.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Strobes from the control side to the counter datapath
  typedef struct packed {
    logic load;       // reload main count from loadCount
    logic runOnLoad;  // running state taken on load
    logic loadGrace;  // first expiry: reload grace count
    logic halt;       // grace expiry: stop the counter
  } wdgStrobe_t;

endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GRACE_TICKS = 1,
  localparam int CW         = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  wdgStrobe_t    strobe,
  input  logic [CW-1:0] loadCount,
  output logic          expire
);

  localparam logic [CW-1:0] GRACE_VAL = CW'(GRACE_TICKS);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] count;
  logic          running;

  assign expire = tickEn && running && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
    end else if (strobe.load) begin
      count   <= loadCount;
      running <= strobe.runOnLoad;
    end else if (strobe.loadGrace) begin
      count   <= GRACE_VAL;
    end else if (strobe.halt) begin
      running <= 1'b0;
    end else if (tickEn && running) begin
      count   <= count - ONE;
    end
  end

  // R5: a running counter never sits at zero
  assert_live_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (count != '0));

  // R5: a plain tick takes exactly one off the count
  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && running && !strobe.load && !strobe.loadGrace && !strobe.halt)
      |=> (count == $past(count) - ONE));

  // R6: a stop command leaves the counter idle
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.runOnLoad) |=> !running);

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int KEY_W     = 7,
  parameter int WORD_W    = 32,
  localparam int CW       = CNT_W + 1,
  localparam int RUN_BIT  = CNT_W,
  localparam int KEY_LSB  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              expire,
  output wdgStrobe_t        strobe,
  output logic [CW-1:0]     loadCount,
  output logic              nmiOut,
  output logic              resetReqOut
);

  logic [WORD_W-1:0] ctrlWord;
  logic              stage;
  logic              accept;
  logic [KEY_W-1:0]  storedKey;
  logic [KEY_W-1:0]  newKey;
  logic [CNT_W-1:0]  newCount;
  logic              locked;

  assign locked    = ctrlWord[RUN_BIT];
  assign storedKey = ctrlWord[KEY_LSB +: KEY_W];
  assign newKey    = wrData[KEY_LSB +: KEY_W];
  assign newCount  = wrData[CNT_W-1:0];
  assign accept    = wrEn && (!locked || (newKey == ~storedKey));

  assign loadCount = (newCount == '0) ? CW'(1 << CNT_W) : {1'b0, newCount};

  always_comb begin
    strobe.load      = accept;
    strobe.runOnLoad = wrData[RUN_BIT];
    strobe.loadGrace = !accept && expire && !stage;
    strobe.halt      = !accept && expire && stage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord    <= '0;
      stage       <= 1'b0;
      nmiOut      <= 1'b0;
      resetReqOut <= 1'b0;
    end else begin
      resetReqOut <= strobe.halt;
      if (accept) begin
        ctrlWord <= wrData;
        stage    <= 1'b0;
        nmiOut   <= 1'b0;
      end else if (strobe.loadGrace) begin
        stage    <= 1'b1;
        nmiOut   <= 1'b1;
      end
    end
  end

  // R9: a valid service write drops the interrupt
  assert_nmi_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !nmiOut);

  // R8: reset request lasts a single cycle
  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReqOut |=> !resetReqOut);

  // R8: reset request only follows the interrupt stage
  assert_reset_after_nmi_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReqOut |-> nmiOut);

  // R3: a rejected write leaves the stored word untouched
  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !accept) |=> $stable(ctrlWord));

endmodule

// File: rtl/watchdog_keyed.sv
module watchdog_keyed
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int KEY_W       = 7,
  parameter int GRACE_TICKS = 1,
  localparam int CW         = CNT_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic        nmiOut,
  output logic        resetReqOut
);

  wdgStrobe_t    strobe;
  logic [CW-1:0] loadCount;
  logic          expire;

  wdg_ctrl #(
    .CNT_W (CNT_W),
    .KEY_W (KEY_W),
    .WORD_W(32)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .expire     (expire),
    .strobe     (strobe),
    .loadCount  (loadCount),
    .nmiOut     (nmiOut),
    .resetReqOut(resetReqOut)
  );

  wdg_datapath #(
    .CNT_W      (CNT_W),
    .GRACE_TICKS(GRACE_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strobe   (strobe),
    .loadCount(loadCount),
    .expire   (expire)
  );

  // R1: nothing is signalled while held in reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rstN |=> (!nmiOut && !resetReqOut));

endmodule

// File: tb/test_watchdog_keyed.sv
module test_watchdog_keyed;

  localparam int CLK_PERIOD = 10;
  localparam int GRACE      = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        nmiOut;
  logic        resetReqOut;

  int compared = 0;
  int mismatched = 0;
  int resetSeen = 0;
  logic [31:0] mdlCtrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  watchdog_keyed #(.CNT_W(8), .KEY_W(7), .GRACE_TICKS(GRACE)) i_watchdog_keyed (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .nmiOut(nmiOut), .resetReqOut(resetReqOut)
  );

  always @(negedge clk) if (rstN && resetReqOut) resetSeen++;

  function automatic logic [31:0] mk(input logic [6:0] key, input logic run, input logic [7:0] cnt);
    return {16'h0, key, run, cnt};
  endfunction

  function automatic logic [6:0] goodKey();
    return mdlCtrl[8] ? ~mdlCtrl[15:9] : 7'h15;
  endfunction

  function automatic logic takes(input logic [31:0] d);
    return !mdlCtrl[8] || (d[15:9] == ~mdlCtrl[15:9]);
  endfunction

  task automatic cyc(input logic t, input logic w, input logic [31:0] d);
    tickEn = t; wrEn = w; wrData = d;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic t = 1'b0);
    logic acc;
    acc = takes(d);
    cyc(t, 1'b1, d);
    if (acc) mdlCtrl = d;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int base;
    int counts [8] = '{0, 1, 2, 3, 5, 8, 17, 255};
    logic [6:0] good;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 nmi after reset", nmiOut, 0);
    chk("R1 reset req after reset", resetReqOut, 0);
    ticks(300);
    chk("R1 no expiry when stopped", nmiOut, 0);
    chk("R1 no reset request when stopped", resetSeen, 0);

    // R2: cleared word is unlocked, any key accepted
    wr(mk(7'h2A, 1'b1, 8'd3));
    ticks(2);
    chk("R2 unlocked write counting", nmiOut, 0);
    ticks(1);
    chk("R2 unlocked write expiry", nmiOut, 1);

    // Sweep of count fields (R4 R5 R7 R8 R9)
    foreach (counts[i]) begin
      int e;
      e = (counts[i] == 0) ? 256 : counts[i];
      wr(mk(goodKey(), 1'b1, counts[i][7:0]));
      chk("R9 nmi cleared by write", nmiOut, 0);
      ticks(e - 1);
      chk("R5 no early expiry", nmiOut, 0);
      ticks(1);
      chk((counts[i] == 0) ? "R4 zero count means 256" : "R7 nmi at expiry", nmiOut, 1);
      chk("R9 first expiry not a reset", resetReqOut, 0);
      base = resetSeen;
      ticks(GRACE - 1);
      chk("R7 nmi held in grace", nmiOut, 1);
      ticks(1);
      chk("R8 reset request on grace expiry", resetReqOut, 1);
      cyc(1'b0, 1'b0, '0);
      chk("R8 reset request one cycle", resetReqOut, 0);
      ticks(20);
      chk("R8 counter stopped after reset request", resetSeen - base, 1);
      chk("R7 nmi held until service", nmiOut, 1);
    end

    // R3: every wrong key is ignored
    wr(mk(goodKey(), 1'b1, 8'd4));
    good = goodKey();
    for (int k = 0; k < 128; k++)
      if (k[6:0] != good) wr(mk(k[6:0], 1'b1, 8'd1));
    ticks(3);
    chk("R3 wrong keys did not reload", nmiOut, 0);
    ticks(1);
    chk("R3 original count expired", nmiOut, 1);
    wr(mk(good, 1'b1, 8'd2));
    chk("R3 correct key accepted", nmiOut, 0);
    ticks(1);
    chk("R3 reload from correct key", nmiOut, 0);
    ticks(1);
    chk("R3 reload expiry", nmiOut, 1);

    // R6: stop command
    wr(mk(goodKey(), 1'b0, 8'd2));
    base = resetSeen;
    ticks(10);
    chk("R6 stopped counter silent", nmiOut, 0);
    chk("R6 stopped counter no reset", resetSeen - base, 0);

    // R2: stopped word unlocked, arbitrary key
    wr(mk(7'h33, 1'b1, 8'd2));
    ticks(2);
    chk("R2 arbitrary key while stopped", nmiOut, 1);

    // R10: write and tick in the same cycle
    wr(mk(goodKey(), 1'b1, 8'd2));
    ticks(1);
    wr(mk(goodKey(), 1'b1, 8'd2), 1'b1);
    chk("R10 write wins", nmiOut, 0);
    ticks(1);
    chk("R10 colliding tick not counted", nmiOut, 0);
    ticks(1);
    chk("R10 expiry after reload", nmiOut, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule